// File: doc/BRIEF.md
# Two-Group Barrel Thread Picker

This unit is the selection stage of an eight-thread in-order barrel core. The eight threads are split into two fixed groups of four. Group 0 holds threads 0 to 3 and group 1 holds threads 4 to 7. Each group feeds its own integer execution slot. In every cycle the picker names at most one thread per group. A thread is named only when it is ready and no long-latency hazard holds it back.

The picker tracks three hazards. The first is an outstanding multiply, which blocks only the thread that issued it. The second is the single shared divider, which is owned exclusively from issue to completion. The third is the spacing between dependent floating-point operations of one thread.

The picker's outputs are combinational, computed from the current inputs and from registered state. The upstream stage presents the ready flags and the decoded operation class of each thread. The multiplier and the divider return completion pulses. The picks issue at the next rising clock edge, and the hazard state and the rotating priorities update at that same edge.

Top module: `bthread_pick`

## Requirements
- R1: While `rst_n` is low at a rising edge, all hazard state is cleared and each group's priority pointer goes to the group's lowest thread. With every thread ready and of class normal, the first cycle after reset picks thread 0 and thread 4.
- R2: Group 0 only ever reports a thread ID in 0..3, and group 1 only ever reports a thread ID in 4..7.
- R3: When no thread of a group is eligible, that group's valid bit is low in that cycle.
- R4: Within a group, the search for a thread starts at the member after the last picked member and wraps around. After reset the search starts at member 0. A thread that is blocked keeps its place in this rotation.
- R5: The class field is `thr_op[2t+1:2t]` for thread t, with 0 normal, 1 multiply, 2 divide and 3 floating point. A thread that issues a multiply is not picked for anything until a `mul_done` pulse arrives with `mul_done_tid` equal to that thread. It becomes eligible in the cycle after that pulse.
- R6: A pending multiply of one thread does not prevent other threads from issuing multiplies, including in the very next cycle.
- R7: From the cycle after a divide issues until `div_done` pulses, no thread is picked for a divide. Threads that present a divide during that time stay unpicked, and they are eligible in the cycle after the pulse.
- R8: When both groups would pick a divide in the same cycle while the divider is free, only group 0's divide issues. Group 1 then picks among its other eligible threads.
- R9: After a thread issues a floating-point operation in cycle k, that thread is not picked for another floating-point operation before cycle k+6. Its operations of other classes are not held back.
- R10: A thread whose ready flag is low is never picked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_ready | input | 8 | Ready flag per thread, bit t for thread t |
| thr_op | input | 16 | Two-bit operation class per thread |
| mul_done | input | 1 | Multiplier completion pulse |
| mul_done_tid | input | 3 | Thread whose multiply completed |
| div_done | input | 1 | Divider completion pulse |
| pick_vld | output | 2 | Bit g is high when group g picked a thread |
| pick_tid | output | 6 | Picked thread ID, bits [3g+2:3g] for group g |

## Verification
The bench drives the corner cases of each hazard directly.

- It issues two multiplies back to back from two threads of one group. A picker that stalled every thread on a pending multiply would lose the second issue. A picker that ignored the completion ID would release the wrong thread.
- It presents one divide in each group while the divider is free. A design without cross-group priority would start two divides at once.
- It holds divide requests against a busy divider and then releases them with the completion pulse. A design that woke one cycle early or late would show a shifted pick.
- It repeats floating-point operations from one thread and checks that exactly five cycles are skipped between issues. An off-by-one in the spacing counter shows up there.
- It runs long random phases. A fixed priority instead of a rotating one would show up as a wrong pick order in those phases.

// File: rtl/bpk_pkg.sv
// Shared definitions for the grouped thread picker.
// Assumes each thread's class is a two-bit code on the issue-side decode bus.
package bpk_pkg;

    typedef enum logic [1:0] {
        OP_ALU = 2'd0,
        OP_MUL = 2'd1,
        OP_DIV = 2'd2,
        OP_FP  = 2'd3
    } op_cls_e;

endpackage

// File: rtl/bpk_rr_arb.sv
// Rotating-priority arbiter for one thread group.
// The search for a request starts at the member after the last grant and wraps around.
// Assumes N is a power of two, so the index wraps by truncation.
module bpk_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic                 gnt_vld,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic [IW-1:0] cand;

    // Find the first request at or after the pointer; the lowest offset wins.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        cand    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            cand = ptr + IW'(i);
            if (req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
    end

    // Move the pointer past the member that was just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (gnt_vld)
            ptr <= gnt_idx + IW'(1);
    end

    assert_idle_when_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !gnt_vld);
    assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]);

endmodule

// File: rtl/bpk_hazard.sv
// Long-latency hazard tracker for all threads.
// Keeps a busy bit per thread for multiplies, one owner flag for the shared divider,
// and a spacing counter per thread for dependent floating-point operations.
// From these it produces the eligibility mask for every thread.
// Assumes the issue inputs are the picks that take effect at the coming edge.
module bpk_hazard
    import bpk_pkg::*;
#(
    parameter int NT     = 8,
    parameter int NG     = 2,
    parameter int FP_GAP = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NT-1:0]             thr_ready,
    input  logic [2*NT-1:0]           thr_op,
    input  logic                      mul_done,
    input  logic [$clog2(NT)-1:0]     mul_done_tid,
    input  logic                      div_done,
    input  logic [NG-1:0]             iss_vld,
    input  logic [NG*$clog2(NT)-1:0]  iss_tid,
    output logic [NT-1:0]             elig
);
    localparam int TW = $clog2(NT);
    localparam int CW = (FP_GAP > 2) ? $clog2(FP_GAP) : 1;

    logic [NT-1:0] mul_busy;
    logic          div_busy;
    logic [CW-1:0] fp_cnt [NT];
    logic [NT-1:0] iss_hit;
    logic [NT-1:0] iss_mul, iss_div, iss_fp;

    // Decode which threads issue this cycle and with which class.
    always_comb begin
        iss_hit = '0;
        for (int g = 0; g < NG; g++)
            if (iss_vld[g])
                iss_hit[iss_tid[g*TW +: TW]] = 1'b1;
        for (int t = 0; t < NT; t++) begin
            iss_mul[t] = iss_hit[t] && (op_cls_e'(thr_op[2*t +: 2]) == OP_MUL);
            iss_div[t] = iss_hit[t] && (op_cls_e'(thr_op[2*t +: 2]) == OP_DIV);
            iss_fp[t]  = iss_hit[t] && (op_cls_e'(thr_op[2*t +: 2]) == OP_FP);
        end
    end

    // Combine readiness with the three hazard conditions per thread.
    always_comb begin
        for (int t = 0; t < NT; t++)
            elig[t] = thr_ready[t] && !mul_busy[t]
                   && !(div_busy && (op_cls_e'(thr_op[2*t +: 2]) == OP_DIV))
                   && !((fp_cnt[t] != '0) && (op_cls_e'(thr_op[2*t +: 2]) == OP_FP));
    end

    // Set the multiply busy bits on issue and clear them on a completion with a matching ID.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mul_busy <= '0;
        else
            for (int t = 0; t < NT; t++)
                if (iss_mul[t])
                    mul_busy[t] <= 1'b1;
                else if (mul_done && (mul_done_tid == TW'(t)))
                    mul_busy[t] <= 1'b0;
    end

    // The divider has one owner from issue until the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_busy <= 1'b0;
        else if (|iss_div)
            div_busy <= 1'b1;
        else if (div_done)
            div_busy <= 1'b0;
    end

    // Load the spacing counter on an FP issue and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++)
                fp_cnt[t] <= '0;
        end else begin
            for (int t = 0; t < NT; t++)
                if (iss_fp[t])
                    fp_cnt[t] <= CW'(FP_GAP - 1);
                else if (fp_cnt[t] != '0)
                    fp_cnt[t] <= fp_cnt[t] - CW'(1);
        end
    end

    assert_div_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (iss_div == '0));
    assert_single_div_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iss_div) <= 1);

    for (genvar t = 0; t < NT; t++) begin : g_chk
        assert_mul_blocks_thread_R5: assert property (@(posedge clk) disable iff (!rst_n)
            mul_busy[t] |-> !iss_hit[t]);
        assert_fp_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
            iss_fp[t] |-> (fp_cnt[t] == '0));
    end

endmodule

// File: rtl/bthread_pick.sv
// Two-group barrel thread picker, the top level.
// Each group of GRP_SIZE threads has its own rotating arbiter over the eligible threads.
// A divide picked by a lower group masks divides in the higher groups in the same cycle.
// Assumes NUM_THREADS is GRP_SIZE times the group count, and both are powers of two.
module bthread_pick
    import bpk_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int GRP_SIZE    = 4,
    parameter int FP_GAP      = 6
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic [NUM_THREADS-1:0]                             thr_ready,
    input  logic [2*NUM_THREADS-1:0]                           thr_op,
    input  logic                                               mul_done,
    input  logic [$clog2(NUM_THREADS)-1:0]                     mul_done_tid,
    input  logic                                               div_done,
    output logic [NUM_THREADS/GRP_SIZE-1:0]                    pick_vld,
    output logic [(NUM_THREADS/GRP_SIZE)*$clog2(NUM_THREADS)-1:0] pick_tid
);
    localparam int NUM_GRP = NUM_THREADS / GRP_SIZE;
    localparam int TIDW    = $clog2(NUM_THREADS);
    localparam int IW      = $clog2(GRP_SIZE);

    logic [NUM_THREADS-1:0] elig;

    bpk_hazard #(.NT(NUM_THREADS), .NG(NUM_GRP), .FP_GAP(FP_GAP)) u_hazard (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_ready    (thr_ready),
        .thr_op       (thr_op),
        .mul_done     (mul_done),
        .mul_done_tid (mul_done_tid),
        .div_done     (div_done),
        .iss_vld      (pick_vld),
        .iss_tid      (pick_tid),
        .elig         (elig)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [GRP_SIZE-1:0] req;
        logic                lower_div;
        logic                took_div;
        logic                gv;
        logic [IW-1:0]       gi;
        logic [TIDW-1:0]     tid;

        if (g == 0) begin : g_first
            assign lower_div = 1'b0;
        end else begin : g_rest
            assign lower_div = g_grp[g-1].lower_div | g_grp[g-1].took_div;
        end

        // Gather this group's eligible members and drop divides already claimed lower down.
        always_comb begin
            for (int j = 0; j < GRP_SIZE; j++)
                req[j] = elig[g*GRP_SIZE + j]
                      && !(lower_div && (op_cls_e'(thr_op[2*(g*GRP_SIZE + j) +: 2]) == OP_DIV));
        end

        bpk_rr_arb #(.N(GRP_SIZE)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .gnt_vld (gv),
            .gnt_idx (gi)
        );

        assign tid      = TIDW'(g * GRP_SIZE) + TIDW'(gi);
        assign took_div = gv && (op_cls_e'(thr_op[2*tid +: 2]) == OP_DIV);
        assign pick_vld[g]                = gv;
        assign pick_tid[g*TIDW +: TIDW]   = tid;

        assert_pick_is_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pick_vld[g] |-> thr_ready[pick_tid[g*TIDW +: TIDW]]);
        assert_pick_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pick_vld[g] |-> (pick_tid[g*TIDW + IW +: TIDW - IW] == (TIDW - IW)'(g)));
    end

endmodule

// File: tb/bthread_pick_bench.sv
`timescale 1ns/1ps
module bthread_pick_bench;
    localparam int MUL_LAT = 5;
    localparam int DIV_LAT = 12;
    localparam int FP_GAP  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  thr_ready = '0;
    logic [15:0] thr_op = '0;
    logic        mul_done = 1'b0;
    logic [2:0]  mul_done_tid = '0;
    logic        div_done = 1'b0;
    logic [1:0]  pick_vld;
    logic [5:0]  pick_tid;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int mcnt [8];
    bit mbusy [8];
    int fcnt [8];
    bit dbusy;
    int dcnt;
    int ptr [2];

    always #2 clk = ~clk;

    bthread_pick u_bthread_pick (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_op(thr_op),
        .mul_done(mul_done), .mul_done_tid(mul_done_tid), .div_done(div_done),
        .pick_vld(pick_vld), .pick_tid(pick_tid)
    );

    function automatic int rr(input bit [3:0] req, input int p);
        for (int i = 0; i < 4; i++)
            if (req[(p + i) % 4]) return (p + i) % 4;
        return -1;
    endfunction

    function automatic logic [15:0] opset(input logic [15:0] base, input int t, input int c);
        logic [15:0] r = base;
        r[2*t +: 2] = 2'(c);
        return r;
    endfunction

    task automatic check(input int g, input int exp_tid, input string lbl);
        bit ev = (exp_tid >= 0);
        n_chk++;
        if (pick_vld[g] !== ev || (ev && pick_tid[3*g +: 3] !== 3'(exp_tid))) begin
            n_bad++;
            $display("FAIL %s group %0d: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
                     lbl, g, pick_vld[g], pick_tid[3*g +: 3], ev, exp_tid);
        end
    endtask

    task automatic step(input logic [7:0] rdy, input logic [15:0] ops, input string lbl);
        int mt = -1;
        int e0, e1, p1;
        bit [7:0] el;
        bit [3:0] r1;
        @(negedge clk);
        thr_ready = rdy;
        thr_op = ops;
        for (int t = 7; t >= 0; t--)
            if (mbusy[t] && mcnt[t] == 0) mt = t;
        mul_done = (mt >= 0);
        mul_done_tid = (mt >= 0) ? 3'(mt) : 3'd0;
        div_done = dbusy && (dcnt == 0);
        #1;
        for (int t = 0; t < 8; t++)
            el[t] = rdy[t] && !mbusy[t] && !(ops[2*t +: 2] == 2 && dbusy)
                 && !(ops[2*t +: 2] == 3 && fcnt[t] != 0);
        e0 = rr(el[3:0], ptr[0]);
        r1 = el[7:4];
        if (e0 >= 0 && ops[2*e0 +: 2] == 2)
            for (int j = 0; j < 4; j++)
                if (ops[2*(4+j) +: 2] == 2) r1[j] = 1'b0;
        e1 = rr(r1, ptr[1]);
        p1 = (e1 >= 0) ? e1 + 4 : -1;
        check(0, e0, lbl);
        check(1, p1, lbl);
        // model state update for the coming edge
        if (mt >= 0) mbusy[mt] = 0;
        if (div_done) dbusy = 0;
        for (int t = 0; t < 8; t++) begin
            if (mbusy[t] && mcnt[t] > 0) mcnt[t]--;
            if (fcnt[t] > 0) fcnt[t]--;
        end
        if (dbusy && dcnt > 0) dcnt--;
        for (int g = 0; g < 2; g++) begin
            int p = (g == 0) ? e0 : p1;
            if (p >= 0) begin
                case (ops[2*p +: 2])
                    2'd1: begin mbusy[p] = 1; mcnt[p] = MUL_LAT - 1; end
                    2'd2: begin dbusy = 1; dcnt = DIV_LAT - 1; end
                    2'd3: fcnt[p] = FP_GAP - 1;
                    default: ;
                endcase
                ptr[g] = (p % 4 + 1) % 4;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 16'h0000, "R3");
    endtask

    initial begin
        logic [15:0] o;
        void'($urandom(32'd20240611));
        for (int t = 0; t < 8; t++) begin mcnt[t] = 0; mbusy[t] = 0; fcnt[t] = 0; end
        dbusy = 0; dcnt = 0; ptr[0] = 0; ptr[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        step(8'hFF, 16'h0000, "R1");
        step(8'hFF, 16'h0000, "R4");
        step(8'hFF, 16'h0000, "R4");
        step(8'h00, 16'h0000, "R3");
        step(8'b0100_1000, 16'h0000, "R10");
        step(8'b0000_0101, 16'h0000, "R4");

        o = opset(opset(16'h0, 0, 1), 1, 1);
        for (int i = 0; i < 10; i++) step(8'b0000_0011, o, "R5 R6");

        idle(20);
        o = opset(opset(16'h0, 1, 2), 2, 2);
        for (int i = 0; i < 30; i++) step(8'b0000_0110, o, "R7");

        idle(20);
        o = opset(opset(16'h0, 0, 2), 4, 2);
        step(8'b0001_0001, o, "R8");
        o = opset(opset(opset(16'h0, 0, 2), 4, 2), 5, 0);
        for (int i = 0; i < 3; i++) step(8'b0011_0001, o, "R8");

        idle(20);
        o = opset(16'h0, 5, 3);
        for (int i = 0; i < 14; i++) step(8'b0010_0000, o, "R9");
        for (int i = 0; i < 8; i++) step(8'b0010_0000, (i % 2) ? o : 16'h0, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            for (int t = 0; t < 8; t++) begin
                r[t] = ($urandom % 10) < 7;
                o[2*t +: 2] = 2'($urandom % 4);
            end
            step(r, o, "R2 R4 R5 R6 R7 R8 R9 R10");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule